// File: doc/BRIEF.md
# SD Host Global Register Wrapper

This block sits in front of one or two SD host slot controllers. It presents a single 4 KB memory-mapped window with 32-bit accesses. The lowest 256 bytes hold the global register file, and each slot controller's own register page follows above it. The global file contains several words with fixed meanings:

- a control/info word whose lowest bit is a self-clearing reset request and whose upper bits report which slots exist;
- a debounce word that resets to 5;
- bus, write-protect polarity and card-detect words, which are plain storage.

Every other word in the global range is also plain storage.

The wrapper also keeps a writable shadow of each slot's capability word and maximum-current word. Software reaches these shadows at fixed offsets in the global range. Each slot controller's interrupt level is sampled into an interrupt status word, and the sampled bits are ORed into one interrupt output. Accesses that fall in a slot's page are passed straight to that slot's sub-port. Reads are registered: the data arrives with a one-cycle valid strobe whatever the target.

Top module: `sdh_glue`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - The info word (offset 0x00) reads with bit 16+i set for each present slot i and all other bits zero. This gives 0x0003_0000 with two slots.
  - The debounce word (0x04) reads 0x0000_0005.
  - The status word (0xFC) and the plain storage words read zero.
  - `irq_o` is low.
- R2: A write to the info word stores bits 31..1 as written and always stores bit 0 as zero.
- R3: The bus word (0x08), write-protect polarity word (0xEC), card-detect word (0xF0) and every other global offset without a special role read back the last full-word value written.
- R4: For each present slot i:
  - The capability shadow at 0x10+0x10*i resets to the parameter CAPS_INIT.
  - The maximum-current shadow at 0x18+0x10*i resets to MAXC_INIT.
  - Both shadows are writable and read back what was written. Writing one slot's shadow leaves the other slot's shadows unchanged.
- R5: Bit i of the status word (0xFC) equals `slot_irq[i]` as sampled at the previous clock edge. All other bits read zero. Writes to 0xFC have no effect.
- R6: `irq_o` is high exactly when at least one status bit of a present slot is set.
- R7: A read request produces exactly one `rsp_valid` pulse, one cycle later, with `rsp_rdata` valid in that cycle. A write produces no response.
- R8: An access counts as partial when `req_strb` is not all ones or when address bits [1:0] are not zero. A partial write changes nothing and is not forwarded. A partial read returns zero.
- R9: A full-word access at offset `(i+1)*0x100 + k` for a present slot i asserts `slot_sel[i]` in the same cycle and drives the following:
  - `slot_addr` = k;
  - `slot_write` and `slot_wdata` from the request.

  A read of such an address returns that slot's `slot_rdata` word one cycle later.
- R10: An access at or above `(NUM_SLOTS+1)*0x100` selects no slot. A read there returns zero and a write there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the 4 KB window |
| req_strb | input | DATA_W/8 | Byte strobes; only all ones is a valid access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W | Read data |
| slot_sel | output | NUM_SLOTS | One-hot select of the slot whose page is accessed |
| slot_write | output | 1 | Forwarded write flag |
| slot_addr | output | log2(GWIN_BYTES) | Forwarded byte offset inside the slot page |
| slot_wdata | output | DATA_W | Forwarded write data |
| slot_rdata | input | NUM_SLOTS*DATA_W | Combinational read data from each slot, slot i at bits [i*DATA_W +: DATA_W] |
| slot_irq | input | NUM_SLOTS | Interrupt level of each slot controller |
| irq_o | output | 1 | Combined interrupt |

## Verification
Properties check the following on every cycle:
- the read strobe timing;
- that at most one slot is selected, and only for an address inside that slot's page;
- that the interrupt output tracks the previous cycle's slot levels;
- that reads of the info word never show the reset bit;
- that out-of-window and partial reads return zero.

Other behaviours depend on history, so only the bench's scenarios can show them:
- reset values;
- that stored words keep the value last written, including the shadows;
- that a partial or out-of-window write left no trace;
- that status writes are ignored;
- that forwarded read data is returned correctly.

// File: rtl/sdh_glue_pkg.sv
package sdh_glue_pkg;

   localparam int MAX_SLOTS     = 2;

   // fixed global word offsets (software-visible layout)
   localparam int OFS_INFO      = 'h00;
   localparam int OFS_DEBOUNCE  = 'h04;
   localparam int OFS_BUS       = 'h08;
   localparam int OFS_WP_POL    = 'hEC;
   localparam int OFS_CARD_DET  = 'hF0;
   localparam int OFS_IRQ_STAT  = 'hFC;

   localparam int INFO_PRESENT_LSB = 16;
   localparam logic [31:0] DEBOUNCE_INIT = 32'h0000_0005;

   typedef enum logic [1:0] {
      RGN_NONE   = 2'd0,
      RGN_GLOBAL = 2'd1,
      RGN_SLOT   = 2'd2
   } region_e;

   function automatic int caps_ofs(int slot);
      return 'h10 + 'h10 * slot;
   endfunction

   function automatic int maxc_ofs(int slot);
      return caps_ofs(slot) + 'h08;
   endfunction

   function automatic bit is_shadow_ofs(int ofs, int nslots);
      for (int i = 0; i < MAX_SLOTS; i++) begin
         if (i < nslots && (ofs == caps_ofs(i) || ofs == maxc_ofs(i))) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic logic [31:0] reg_init(int ofs, int nslots);
      logic [31:0] v;
      v = '0;
      if (ofs == OFS_INFO) begin
         for (int i = 0; i < MAX_SLOTS; i++) begin
            if (i < nslots) v[INFO_PRESENT_LSB + i] = 1'b1;
         end
      end else if (ofs == OFS_DEBOUNCE) begin
         v = DEBOUNCE_INIT;
      end
      return v;
   endfunction

   function automatic logic [31:0] write_mask(int ofs);
      return (ofs == OFS_INFO) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/sdh_glue_decode.sv
module sdh_glue_decode
   import sdh_glue_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_SLOTS = 2,
   parameter int WIN_LSB   = 8,
   parameter int STRB_W    = 4,
   localparam int PAGE_W   = ADDR_W - WIN_LSB,
   localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int WIDX_W   = WIN_LSB - 2
)(
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [STRB_W-1:0]    req_strb,
   output logic                 access_ok,
   output region_e              rgn,
   output logic [SEL_W-1:0]     slot_idx,
   output logic [WIDX_W-1:0]    word_idx,
   output logic [NUM_SLOTS-1:0] slot_hit
);

   logic [PAGE_W-1:0] page;

   assign page      = req_addr[ADDR_W-1:WIN_LSB];
   assign word_idx  = req_addr[WIN_LSB-1:2];
   assign access_ok = req_valid && (&req_strb) && (req_addr[1:0] == 2'b00);
   assign slot_idx  = SEL_W'(page - PAGE_W'(1));

   always_comb begin
      if (page == '0)                          rgn = RGN_GLOBAL;
      else if (page <= PAGE_W'(NUM_SLOTS))     rgn = RGN_SLOT;
      else                                     rgn = RGN_NONE;
   end

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
         assign slot_hit[i] = access_ok && (page == PAGE_W'(i + 1));
      end
   endgenerate

endmodule

// File: rtl/sdh_glue_gregs.sv
module sdh_glue_gregs
   import sdh_glue_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int DATA_W    = 32,
   parameter int WORDS     = 64,
   localparam int IDX_W    = $clog2(WORDS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [DATA_W-1:0]    rdata,
   input  logic [NUM_SLOTS-1:0] irq_stat
);

   logic [WORDS-1:0][DATA_W-1:0] words;

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         localparam int OFS = w * 4;
         if (OFS == OFS_IRQ_STAT) begin : g_stat
            // status word mirrors the sampled slot levels; writes ignored
            assign words[w] = DATA_W'(irq_stat);
         end else if (is_shadow_ofs(OFS, NUM_SLOTS)) begin : g_hole
            // served by the slot shadow registers instead
            assign words[w] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= DATA_W'(reg_init(OFS, NUM_SLOTS));
               else if (wr_en && wr_idx == IDX_W'(w))
                  q <= wdata & DATA_W'(write_mask(OFS));
            end
            assign words[w] = q;
         end
      end
   endgenerate

   assign rdata = words[rd_idx];

endmodule

// File: rtl/sdh_glue_shadow.sv
module sdh_glue_shadow #(
   parameter int          DATA_W    = 32,
   parameter logic [31:0] CAPS_INIT = 32'h0,
   parameter logic [31:0] MAXC_INIT = 32'h0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              caps_we,
   input  logic              maxc_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] caps_q,
   output logic [DATA_W-1:0] maxc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         caps_q <= DATA_W'(CAPS_INIT);
         maxc_q <= DATA_W'(MAXC_INIT);
      end else begin
         if (caps_we) caps_q <= wdata;
         if (maxc_we) maxc_q <= wdata;
      end
   end

endmodule

// File: rtl/sdh_glue_irq.sv
module sdh_glue_irq #(
   parameter int NUM_SLOTS = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] slot_irq,
   output logic [NUM_SLOTS-1:0] stat_q,
   output logic                 irq_o
);

   // each status bit follows its slot's level, set on high and cleared on low
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= slot_irq;
   end

   assign irq_o = |stat_q;

endmodule

// File: rtl/sdh_glue.sv
module sdh_glue
   import sdh_glue_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          NUM_SLOTS  = 2,
   parameter int          GWIN_BYTES = 256,
   parameter logic [31:0] CAPS_INIT  = 32'h01E8_0C8A,
   parameter logic [31:0] MAXC_INIT  = 32'h0000_0000,
   localparam int         STRB_W     = DATA_W / 8,
   localparam int         WIN_LSB    = $clog2(GWIN_BYTES),
   localparam int         WIDX_W     = WIN_LSB - 2,
   localparam int         WORDS      = GWIN_BYTES / 4,
   localparam int         SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic                           req_write,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [STRB_W-1:0]              req_strb,
   input  logic [DATA_W-1:0]              req_wdata,
   output logic                           rsp_valid,
   output logic [DATA_W-1:0]              rsp_rdata,
   output logic [NUM_SLOTS-1:0]           slot_sel,
   output logic                           slot_write,
   output logic [WIN_LSB-1:0]             slot_addr,
   output logic [DATA_W-1:0]              slot_wdata,
   input  logic [NUM_SLOTS*DATA_W-1:0]    slot_rdata,
   input  logic [NUM_SLOTS-1:0]           slot_irq,
   output logic                           irq_o
);

   // elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("sdh_glue: DATA_W must be 32");
      end
      if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
         $error("sdh_glue: NUM_SLOTS must be 1 or 2");
      end
      if (GWIN_BYTES < 256 || (1 << WIN_LSB) != GWIN_BYTES) begin : g_bad_win
         $error("sdh_glue: GWIN_BYTES must be a power of two, at least 256");
      end
      if ((NUM_SLOTS + 1) * GWIN_BYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("sdh_glue: ADDR_W too narrow for the slot pages");
      end
   endgenerate

   logic                 access_ok;
   region_e              rgn;
   logic [SEL_W-1:0]     slot_idx;
   logic [WIDX_W-1:0]    word_idx;
   logic [NUM_SLOTS-1:0] slot_hit;

   sdh_glue_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_SLOTS(NUM_SLOTS),
      .WIN_LSB  (WIN_LSB),
      .STRB_W   (STRB_W)
   ) u_decode (
      .req_valid(req_valid),
      .req_addr (req_addr),
      .req_strb (req_strb),
      .access_ok(access_ok),
      .rgn      (rgn),
      .slot_idx (slot_idx),
      .word_idx (word_idx),
      .slot_hit (slot_hit)
   );

   logic global_wr;
   assign global_wr = access_ok && req_write && (rgn == RGN_GLOBAL);

   // interrupt sampling
   logic [NUM_SLOTS-1:0] irq_stat;

   sdh_glue_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_irq(slot_irq),
      .stat_q  (irq_stat),
      .irq_o   (irq_o)
   );

   // global register file
   logic [DATA_W-1:0] greg_rdata;

   sdh_glue_gregs #(
      .NUM_SLOTS(NUM_SLOTS),
      .DATA_W   (DATA_W),
      .WORDS    (WORDS)
   ) u_gregs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (global_wr),
      .wr_idx  (word_idx),
      .wdata   (req_wdata),
      .rd_idx  (word_idx),
      .rdata   (greg_rdata),
      .irq_stat(irq_stat)
   );

   // per-slot capability / max-current shadows
   logic [NUM_SLOTS-1:0][DATA_W-1:0] caps_q;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] maxc_q;
   logic [NUM_SLOTS-1:0]             caps_hit;
   logic [NUM_SLOTS-1:0]             maxc_hit;

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         assign caps_hit[i] = (word_idx == WIDX_W'(caps_ofs(i) / 4));
         assign maxc_hit[i] = (word_idx == WIDX_W'(maxc_ofs(i) / 4));

         sdh_glue_shadow #(
            .DATA_W   (DATA_W),
            .CAPS_INIT(CAPS_INIT),
            .MAXC_INIT(MAXC_INIT)
         ) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .caps_we(global_wr && caps_hit[i]),
            .maxc_we(global_wr && maxc_hit[i]),
            .wdata  (req_wdata),
            .caps_q (caps_q[i]),
            .maxc_q (maxc_q[i])
         );
      end
   endgenerate

   logic [DATA_W-1:0] shadow_rdata;
   logic              shadow_sel;

   always_comb begin
      shadow_rdata = '0;
      shadow_sel   = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (caps_hit[i]) begin
            shadow_rdata = caps_q[i];
            shadow_sel   = 1'b1;
         end
         if (maxc_hit[i]) begin
            shadow_rdata = maxc_q[i];
            shadow_sel   = 1'b1;
         end
      end
   end

   // forwarding to slot pages
   assign slot_sel   = slot_hit;
   assign slot_write = req_write;
   assign slot_addr  = req_addr[WIN_LSB-1:0];
   assign slot_wdata = req_wdata;

   // read data selection and response register
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (access_ok && !req_write) begin
         unique case (rgn)
            RGN_GLOBAL: rd_next = shadow_sel ? shadow_rdata : greg_rdata;
            RGN_SLOT:   rd_next = slot_rdata[int'(slot_idx) * DATA_W +: DATA_W];
            default:    rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/sdh_glue_chk.sv
module sdh_glue_chk #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NUM_SLOTS  = 2,
   parameter int GWIN_BYTES = 256,
   localparam int STRB_W    = DATA_W / 8,
   localparam int WIN_LSB   = $clog2(GWIN_BYTES),
   localparam int PAGE_W    = ADDR_W - WIN_LSB
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [ADDR_W-1:0]    req_addr,
   input logic [STRB_W-1:0]    req_strb,
   input logic                 rsp_valid,
   input logic [DATA_W-1:0]    rsp_rdata,
   input logic [NUM_SLOTS-1:0] slot_sel,
   input logic [NUM_SLOTS-1:0] slot_irq,
   input logic                 irq_o
);

   logic [PAGE_W-1:0] page;
   logic              rd_full;
   assign page    = req_addr[ADDR_W-1:WIN_LSB];
   assign rd_full = req_valid && !req_write && (&req_strb) && (req_addr[1:0] == 2'b00);

   // R7
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rsp_valid == $past(req_valid && !req_write)));

   // R6
   irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq_o == (|$past(slot_irq))));

   // R9
   single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel));

   // R10
   slot_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_sel) |-> (req_valid && page != '0 && page <= PAGE_W'(NUM_SLOTS)));

   // R2
   info_bit0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_full && req_addr == '0)) |-> (rsp_rdata[0] == 1'b0));

   // R10
   outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_full && page > PAGE_W'(NUM_SLOTS))) |-> (rsp_rdata == '0));

   // R8
   partial_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_valid && !req_write && !((&req_strb) && req_addr[1:0] == 2'b00)))
      |-> (rsp_rdata == '0));

endmodule

bind sdh_glue sdh_glue_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_SLOTS (NUM_SLOTS),
   .GWIN_BYTES(GWIN_BYTES)
) u_chk (.*);

// File: tb/sim_sdh_glue.sv
`timescale 1ns/1ps
module sim_sdh_glue;

   localparam int          ADDR_W = 12;
   localparam int          NSL    = 2;
   localparam logic [31:0] CAPS   = 32'h01E8_0C8A;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [3:0]        req_strb = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic [31:0]       rsp_rdata;
   logic [NSL-1:0]    slot_sel;
   logic              slot_write;
   logic [7:0]        slot_addr;
   logic [31:0]       slot_wdata;
   logic [NSL*32-1:0] slot_rdata;
   logic [NSL-1:0]    slot_irq = '0;
   logic              irq_o;

   always #2 clk = ~clk;

   sdh_glue #(.ADDR_W(ADDR_W), .NUM_SLOTS(NSL), .CAPS_INIT(CAPS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slot_sel(slot_sel),
      .slot_write(slot_write), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
      .slot_rdata(slot_rdata), .slot_irq(slot_irq), .irq_o(irq_o)
   );

   // slot controller model: selected slot answers with a tagged word
   always_comb begin
      for (int i = 0; i < NSL; i++)
         slot_rdata[i*32 +: 32] = slot_sel[i] ?
            (32'h5A00_0000 | (32'(i) << 16) | 32'(slot_addr)) : 32'h0;
   end

   int          checks = 0;
   int          errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [NSL-1:0] last_sel;
   logic [7:0]     last_addr;
   logic [31:0]    last_wdata;
   logic           last_write;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [3:0] s,
                           input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_strb = s;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_strb = s; req_wdata = d;
      #1;
      last_sel = slot_sel; last_addr = slot_addr; last_wdata = slot_wdata; last_write = slot_write;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b0, "R7 write gives no response", 32'(rsp_valid), 32'h0);
   endtask

   // monitor: scoreboard pops one expected item per response
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected response", rsp_rdata, 32'h0);
            end else begin
               logic [31:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rsp_rdata == e, t, rsp_rdata, e);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_o == 1'b0, "R1 irq low after reset", 32'(irq_o), 32'h0);
      check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);

      // R1 reset values
      bus_read(12'h000, 4'hF, 32'h0003_0000, "R1 info reset");
      bus_read(12'h004, 4'hF, 32'h0000_0005, "R1 debounce reset");
      bus_read(12'h008, 4'hF, 32'h0, "R1 bus reset");
      bus_read(12'h0FC, 4'hF, 32'h0, "R1 status reset");
      bus_read(12'h0F0, 4'hF, 32'h0, "R1 card detect reset");
      // R4 shadow reset
      bus_read(12'h010, 4'hF, CAPS, "R4 caps0 reset");
      bus_read(12'h020, 4'hF, CAPS, "R4 caps1 reset");
      bus_read(12'h018, 4'hF, 32'h0, "R4 maxc0 reset");

      // R2 self-clearing bit
      bus_write(12'h000, 32'hDEAD_BEEF, 4'hF);
      bus_read(12'h000, 4'hF, 32'hDEAD_BEEE, "R2 info keeps upper bits");
      bus_write(12'h000, 32'h0000_0001, 4'hF);
      bus_read(12'h000, 4'hF, 32'h0, "R2 info bit0 never stored");

      // R3 storage words
      bus_write(12'h008, 32'h1234_5678, 4'hF);
      bus_write(12'h0EC, 32'hA5A5_0001, 4'hF);
      bus_write(12'h0F0, 32'h0000_00FF, 4'hF);
      bus_write(12'h040, 32'hCAFE_F00D, 4'hF);
      bus_read(12'h008, 4'hF, 32'h1234_5678, "R3 bus word");
      bus_read(12'h0EC, 4'hF, 32'hA5A5_0001, "R3 wp polarity word");
      bus_read(12'h0F0, 4'hF, 32'h0000_00FF, "R3 card detect word");
      bus_read(12'h040, 4'hF, 32'hCAFE_F00D, "R3 generic word");

      // R4 shadows writable and independent
      bus_write(12'h010, 32'h1111_2222, 4'hF);
      bus_write(12'h028, 32'h3333_4444, 4'hF);
      bus_read(12'h010, 4'hF, 32'h1111_2222, "R4 caps0 written");
      bus_read(12'h028, 4'hF, 32'h3333_4444, "R4 maxc1 written");
      bus_read(12'h020, 4'hF, CAPS, "R4 caps1 untouched");
      bus_read(12'h018, 4'hF, 32'h0, "R4 maxc0 untouched");

      // R8 partial accesses
      bus_write(12'h008, 32'h0, 4'h3);
      check(last_sel == '0, "R8 partial write not forwarded", 32'(last_sel), 32'h0);
      bus_read(12'h008, 4'hF, 32'h1234_5678, "R8 partial write ignored");
      bus_read(12'h008, 4'h1, 32'h0, "R8 partial strobe read zero");
      bus_read(12'h009, 4'hF, 32'h0, "R8 misaligned read zero");
      bus_write(12'h124, 32'h7777_0000, 4'h7);
      check(last_sel == '0, "R8 partial slot write not forwarded", 32'(last_sel), 32'h0);

      // R10 outside the slot pages
      bus_write(12'h300, 32'hFFFF_FFFF, 4'hF);
      check(last_sel == '0, "R10 no slot selected", 32'(last_sel), 32'h0);
      bus_read(12'h300, 4'hF, 32'h0, "R10 read above slots");
      bus_read(12'hFFC, 4'hF, 32'h0, "R10 read top of window");
      bus_read(12'h000, 4'hF, 32'h0, "R10 stray write left info");

      // R9 forwarding
      bus_write(12'h124, 32'h0000_ABCD, 4'hF);
      check(last_sel == 2'b01, "R9 slot0 selected", 32'(last_sel), 32'h1);
      check(last_addr == 8'h24, "R9 slot offset", 32'(last_addr), 32'h24);
      check(last_wdata == 32'h0000_ABCD, "R9 slot wdata", last_wdata, 32'h0000_ABCD);
      check(last_write == 1'b1, "R9 slot write flag", 32'(last_write), 32'h1);
      bus_write(12'h2FC, 32'h0000_0001, 4'hF);
      check(last_sel == 2'b10, "R9 slot1 selected", 32'(last_sel), 32'h2);
      bus_read(12'h240, 4'hF, 32'h5A01_0040, "R9 slot1 read data");
      bus_read(12'h17C, 4'hF, 32'h5A00_007C, "R9 slot0 read data");

      // R5 / R6 interrupts
      @(negedge clk);
      slot_irq = 2'b10;
      @(negedge clk);
      check(irq_o == 1'b1, "R6 irq from slot1", 32'(irq_o), 32'h1);
      bus_read(12'h0FC, 4'hF, 32'h2, "R5 status slot1");
      bus_write(12'h0FC, 32'hFFFF_FFFF, 4'hF);
      bus_read(12'h0FC, 4'hF, 32'h2, "R5 status write ignored");
      @(negedge clk);
      slot_irq = 2'b01;
      @(negedge clk);
      check(irq_o == 1'b1, "R6 irq from slot0", 32'(irq_o), 32'h1);
      bus_read(12'h0FC, 4'hF, 32'h1, "R5 status follows level");
      @(negedge clk);
      slot_irq = 2'b00;
      @(negedge clk);
      check(irq_o == 1'b0, "R6 irq cleared", 32'(irq_o), 32'h0);
      bus_read(12'h0FC, 4'hF, 32'h0, "R5 status cleared");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R7 all reads answered", 32'(exp_q.size()), 32'h0);
      finish_run();
   end

endmodule